// File: doc/BRIEF.md
# 64-Source Interrupt Controller

This block gathers up to 64 active-low interrupt inputs and turns them into one active-high request for the processor. Each source owns one bit in a pair of 32-bit state words, called the upper and lower words. Which word and which bit a source uses follows a fixed, scattered table rather than the source number. Software sees per-source enable (mask) words and per-source pending words through a small register port. The pending words are cleared by writing ones. A vector register names the lowest-numbered source that is both pending and enabled.

Most sources are sensed as a low level. External sources 19 to 25 and port sources 48 to 63 can instead be switched to falling-edge sensing through an edge-select word. Two 32-bit priority words and one 16-bit configuration word are kept as plain storage with fixed reset values. They have no effect on arbitration. Source numbers 0 and 31 are reserved: number 0 doubles as the "nothing active" vector, and source 31 would share a bit with source 18.

The register port takes one access per cycle and never stalls, so there is no back-pressure. A read request presented with `bus_valid` high and `bus_write` low returns `rd_valid` high with `rd_data` one cycle later. The data shows the state from before that clock edge. A write takes effect at the clock edge that accepts it.

Top module: `icx_top`

## Requirements
- R1: After reset, the registers read as follows. Both mask words (addresses 0 and 1) read 0, both pending words (2 and 3) read 0, the edge-select word (4) reads 0 and the vector (5) reads 0. Both priority words (6 and 7) read 0x05309770 and the configuration word (8) reads 0.
- R2: Inputs of sources 0 and 31 never set any pending bit.
- R3: Sources 0–15 and 32–47 use the upper words (mask address 0, pending address 2); all other sources use the lower words (1 and 3). Bit positions are as follows:
  - sources 1–15 use bits 15 down to 1;
  - sources 16–18 use bits 2, 1, 0;
  - sources 19–30 use bits 14 down to 3;
  - sources 32–47 use bits 31 down to 16;
  - sources 48–63 use bits 16 up to 31.
- R4: A mask bit of 1 enables its source. `irq_req` is high in the cycle after any pending bit whose mask bit is 1 becomes set, and low otherwise. Mask words read back as written.
- R5: Writing a pending word clears each bit written as 1. Bits written as 0 are unchanged.
- R6: A level-sensed source sets its pending bit at every clock edge where its input is low. In the same cycle, setting wins over a software clear.
- R7: An edge-capable source whose edge-select bit is 1 sets pending only on a high-to-low transition. A low input that is held, or a rising input, sets nothing. The edge-select bit is 14−(s−19) for sources 19–25 and 31−(63−s) for sources 48–63. Only these bits are stored (mask 0xFFFF7F00); the others read 0. The edge-select bits have no effect on any other source.
- R8: The vector register (address 5) reads {source number, 26'b0}, where the source number is the lowest-numbered source that is both pending and enabled, and reads 0 when no such source exists.
- R9: A read returns on `rd_valid` exactly one cycle after the request. Writes to the vector register are ignored. The priority words store all 32 bits and the configuration word stores bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_n | input | 64 | Interrupt inputs, active low, index = source number |
| bus_valid | input | 1 | Register access request, accepted every cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| irq_req | output | 1 | Active-high processor interrupt request |

## Verification
An input low at a clock edge shows in the pending words at that same edge. A pending word or the vector can therefore be requested in the next cycle, and its response arrives on `rd_valid` one cycle after the request. The bench drives inputs and requests on falling edges and records each expected read value in a queue when the request is issued. A monitor pops the queue whenever `rd_valid` is seen on a falling edge, which holds each comparison to the one-cycle response latency. `irq_req` is combinational from registered state, so it is compared on the falling edge that follows the write or input pulse that changed it.

// File: rtl/icx_pkg.sv
package icx_pkg;

  localparam int NSRC   = 64;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 4;
  localparam int VEC_W  = $clog2(NSRC);

  localparam logic [ADDR_W-1:0] A_MASK_HI = 4'd0;
  localparam logic [ADDR_W-1:0] A_MASK_LO = 4'd1;
  localparam logic [ADDR_W-1:0] A_PEND_HI = 4'd2;
  localparam logic [ADDR_W-1:0] A_PEND_LO = 4'd3;
  localparam logic [ADDR_W-1:0] A_EDGE    = 4'd4;
  localparam logic [ADDR_W-1:0] A_VEC     = 4'd5;
  localparam logic [ADDR_W-1:0] A_PRIO_A  = 4'd6;
  localparam logic [ADDR_W-1:0] A_PRIO_B  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CFG     = 4'd8;

  // edge-select bits that exist: 8..14 (external) and 16..31 (port)
  localparam logic [WORD_W-1:0] EDGE_IMPL = 32'hFFFF_7F00;

  function automatic logic src_reserved(int s);
    return (s == 0) || (s == 31);
  endfunction

  function automatic logic src_in_hi(int s);
    return (s < 16) || ((s >= 32) && (s < 48));
  endfunction

  function automatic int src_bit(int s);
    if (s < 1)       return 0;
    else if (s < 16) return 16 - s;
    else if (s < 19) return 18 - s;
    else if (s < 31) return 33 - s;
    else if (s < 32) return 0;
    else if (s < 48) return 63 - s;
    else             return s - 32;
  endfunction

  function automatic logic src_edge_cap(int s);
    return ((s >= 19) && (s <= 25)) || ((s >= 48) && (s <= 63));
  endfunction

  function automatic int src_edge_bit(int s);
    if ((s >= 19) && (s <= 25))      return 33 - s;
    else if ((s >= 48) && (s <= 63)) return s - 32;
    else                             return 0;
  endfunction

endpackage

// File: rtl/icx_sense.sv
module icx_sense
  import icx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_n,
  input  logic [WORD_W-1:0] edge_sel,
  output logic [WORD_W-1:0] set_hi,
  output logic [WORD_W-1:0] set_lo
);

  logic [NSRC-1:0] hit;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    if (src_reserved(s)) begin : g_rsv
      assign hit[s] = 1'b0;
    end else if (src_edge_cap(s)) begin : g_edge
      localparam int EB = src_edge_bit(s);
      logic prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= src_n[s];
      end
      assign hit[s] = edge_sel[EB] ? (prev_q & ~src_n[s]) : ~src_n[s];
    end else begin : g_lvl
      assign hit[s] = ~src_n[s];
    end
  end

  logic unused_inputs;
  assign unused_inputs = ^{src_n[0], src_n[31], edge_sel[7:0], edge_sel[15]};

  always_comb begin
    set_hi = '0;
    set_lo = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (!src_reserved(s)) begin
        if (src_in_hi(s)) set_hi[src_bit(s)] = set_hi[src_bit(s)] | hit[s];
        else              set_lo[src_bit(s)] = set_lo[src_bit(s)] | hit[s];
      end
    end
  end

endmodule

// File: rtl/icx_arbiter.sv
module icx_arbiter
  import icx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] pend_hi,
  input  logic [WORD_W-1:0] pend_lo,
  input  logic [WORD_W-1:0] mask_hi,
  input  logic [WORD_W-1:0] mask_lo,
  output logic [VEC_W-1:0]  vec_num
);

  logic [NSRC-1:0] act;

  always_comb begin
    act = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (!src_reserved(s)) begin
        if (src_in_hi(s)) act[s] = pend_hi[src_bit(s)] & mask_hi[src_bit(s)];
        else              act[s] = pend_lo[src_bit(s)] & mask_lo[src_bit(s)];
      end
    end
  end

  // lowest-numbered active source wins
  always_comb begin
    vec_num = '0;
    for (int s = NSRC - 1; s >= 1; s--) begin
      if (act[s]) vec_num = VEC_W'(s);
    end
  end

  a_r8_winner_active: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_num != '0) |-> act[vec_num]);

endmodule

// File: rtl/icx_regs.sv
module icx_regs
  import icx_pkg::*;
#(
  parameter logic [WORD_W-1:0] PRIO_RST = 32'h0530_9770,
  parameter int                CFG_W    = 16,
  parameter logic [CFG_W-1:0]  CFG_RST  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] set_hi,
  input  logic [WORD_W-1:0] set_lo,
  input  logic [VEC_W-1:0]  vec_num,
  output logic [WORD_W-1:0] mask_hi,
  output logic [WORD_W-1:0] mask_lo,
  output logic [WORD_W-1:0] pend_hi,
  output logic [WORD_W-1:0] pend_lo,
  output logic [WORD_W-1:0] edge_sel,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);

  localparam int VEC_SHIFT = WORD_W - VEC_W;

  logic [WORD_W-1:0] prio_a, prio_b;
  logic [CFG_W-1:0]  cfg_q;
  logic              wr_en, rd_en;
  logic [WORD_W-1:0] clr_hi, clr_lo, rmux;

  assign wr_en  = bus_valid & bus_write;
  assign rd_en  = bus_valid & ~bus_write;
  assign clr_hi = (wr_en && bus_addr == A_PEND_HI) ? bus_wdata : '0;
  assign clr_lo = (wr_en && bus_addr == A_PEND_LO) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_hi  <= '0;
      mask_lo  <= '0;
      pend_hi  <= '0;
      pend_lo  <= '0;
      edge_sel <= '0;
      prio_a   <= PRIO_RST;
      prio_b   <= PRIO_RST;
      cfg_q    <= CFG_RST;
    end else begin
      pend_hi <= (pend_hi & ~clr_hi) | set_hi;
      pend_lo <= (pend_lo & ~clr_lo) | set_lo;
      if (wr_en) begin
        case (bus_addr)
          A_MASK_HI: mask_hi  <= bus_wdata;
          A_MASK_LO: mask_lo  <= bus_wdata;
          A_EDGE:    edge_sel <= bus_wdata & EDGE_IMPL;
          A_PRIO_A:  prio_a   <= bus_wdata;
          A_PRIO_B:  prio_b   <= bus_wdata;
          A_CFG:     cfg_q    <= bus_wdata[CFG_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_MASK_HI: rmux = mask_hi;
      A_MASK_LO: rmux = mask_lo;
      A_PEND_HI: rmux = pend_hi;
      A_PEND_LO: rmux = pend_lo;
      A_EDGE:    rmux = edge_sel;
      A_VEC:     rmux = {vec_num, {VEC_SHIFT{1'b0}}};
      A_PRIO_A:  rmux = prio_a;
      A_PRIO_B:  rmux = prio_b;
      A_CFG:     rmux = {{(WORD_W-CFG_W){1'b0}}, cfg_q};
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rmux;
    end
  end

  a_r5_clear_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == A_PEND_HI) |=>
      ((pend_hi & $past(bus_wdata) & ~$past(set_hi)) == '0));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_lo != '0) |=> ((pend_lo & $past(set_lo)) == $past(set_lo)));

endmodule

// File: rtl/icx_top.sv
module icx_top
  import icx_pkg::*;
#(
  parameter logic [31:0] PRIO_RST = 32'h0530_9770,
  parameter logic [15:0] CFG_RST  = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       src_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              irq_req
);

  logic [WORD_W-1:0] set_hi, set_lo;
  logic [WORD_W-1:0] mask_hi, mask_lo, pend_hi, pend_lo, edge_sel;
  logic [VEC_W-1:0]  vec_num;

  icx_sense u_sense (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_n    (src_n),
    .edge_sel (edge_sel),
    .set_hi   (set_hi),
    .set_lo   (set_lo)
  );

  icx_arbiter u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_hi (pend_hi),
    .pend_lo (pend_lo),
    .mask_hi (mask_hi),
    .mask_lo (mask_lo),
    .vec_num (vec_num)
  );

  icx_regs #(
    .PRIO_RST (PRIO_RST),
    .CFG_W    (16),
    .CFG_RST  (CFG_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .set_hi    (set_hi),
    .set_lo    (set_lo),
    .vec_num   (vec_num),
    .mask_hi   (mask_hi),
    .mask_lo   (mask_lo),
    .pend_hi   (pend_hi),
    .pend_lo   (pend_lo),
    .edge_sel  (edge_sel),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  assign irq_req = |(pend_hi & mask_hi) | |(pend_lo & mask_lo);

  a_r4_req_matches_vec: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (vec_num != '0));

endmodule

// File: tb/icx_top_tb.sv
module icx_top_tb;

  localparam logic [3:0] MHI = 4'd0, MLO = 4'd1, PHI = 4'd2, PLO = 4'd3,
                         EDG = 4'd4, VEC = 4'd5, PRA = 4'd6, PRB = 4'd7, CFG = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_n = '1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid, irq_req;
  logic [31:0] rd_data;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  icx_top u_dut (
    .clk(clk), .rst_n(rst_n), .src_n(src_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq_req(irq_req)
  );

  // reference mapping from the requirements
  function automatic bit ref_hi(int s);
    return (s inside {[0:15]}) || (s inside {[32:47]});
  endfunction
  function automatic int ref_bit(int s);
    if (s inside {[1:15]})  return 16 - s;
    if (s inside {[16:18]}) return 18 - s;
    if (s inside {[19:30]}) return 33 - s;
    if (s inside {[32:47]}) return 63 - s;
    if (s inside {[48:63]}) return s - 32;
    return 0;
  endfunction
  function automatic logic [31:0] onehot(int b);
    return 32'(1) << b;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    q_exp.push_back(e); q_tag.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s: got %0b expected %0b", tag, act, e);
    end
  endtask

  task automatic pulse(input int s);
    src_n[s] = 1'b0;
    @(negedge clk);
    src_n[s] = 1'b1;
  endtask

  // monitor: pop expected value for each read response
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (q_exp.size() == 0) begin
        failures++;
        $display("FAIL R9: unexpected response got %h expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (rd_data !== e) begin
          failures++;
          $display("FAIL %s: got %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(rd_valid, 1'b0, "R9 idle rd_valid");
    chk(irq_req, 1'b0, "R1 irq after reset");
    rd(MHI, 32'h0, "R1 mask_hi"); rd(MLO, 32'h0, "R1 mask_lo");
    rd(PHI, 32'h0, "R1 pend_hi"); rd(PLO, 32'h0, "R1 pend_lo");
    rd(EDG, 32'h0, "R1 edge");    rd(VEC, 32'h0, "R1 vec");
    rd(PRA, 32'h0530_9770, "R1 prio_a"); rd(PRB, 32'h0530_9770, "R1 prio_b");
    rd(CFG, 32'h0, "R1 cfg");

    // R4 masked source stays silent, then unmask
    pulse(5);
    chk(irq_req, 1'b0, "R4 masked no irq");
    rd(PHI, onehot(11), "R3 src5 pending");
    rd(VEC, 32'h0, "R8 masked vec zero");
    wr(MHI, onehot(11));
    chk(irq_req, 1'b1, "R4 unmasked irq");
    rd(MHI, onehot(11), "R4 mask readback");
    rd(VEC, 32'd5 << 26, "R8 vec src5");

    // R5 write-one-to-clear
    wr(PHI, 32'h0);
    rd(PHI, onehot(11), "R5 zero write keeps");
    wr(PHI, onehot(11));
    chk(irq_req, 1'b0, "R5 irq after clear");
    rd(PHI, 32'h0, "R5 cleared");
    wr(MHI, 32'h0);

    // R3 full mapping sweep
    for (int s = 1; s < 64; s++) begin
      if (s != 31) begin
        pulse(s);
        if (ref_hi(s)) begin
          rd(PHI, onehot(ref_bit(s)), $sformatf("R3 src%0d hi", s));
          rd(PLO, 32'h0, $sformatf("R3 src%0d lo", s));
        end else begin
          rd(PHI, 32'h0, $sformatf("R3 src%0d hi", s));
          rd(PLO, onehot(ref_bit(s)), $sformatf("R3 src%0d lo", s));
        end
        wr(PHI, '1); wr(PLO, '1);
      end
    end
    chk(irq_req, 1'b0, "R4 all masked during sweep");

    // R2 reserved sources
    src_n[0] = 1'b0; src_n[31] = 1'b0;
    @(negedge clk); @(negedge clk);
    src_n[0] = 1'b1; src_n[31] = 1'b1;
    rd(PHI, 32'h0, "R2 reserved hi");
    rd(PLO, 32'h0, "R2 reserved lo");

    // R6 held level beats clear
    wr(MHI, '1); wr(MLO, '1);
    src_n[40] = 1'b0;
    @(negedge clk);
    wr(PHI, '1);
    rd(PHI, onehot(23), "R6 level re-sets");
    chk(irq_req, 1'b1, "R6 irq while held");
    src_n[40] = 1'b1;
    @(negedge clk);
    wr(PHI, '1);
    rd(PHI, 32'h0, "R6 released cleared");
    chk(irq_req, 1'b0, "R6 irq after release");

    // R7 edge sensing
    wr(EDG, '1);
    rd(EDG, 32'hFFFF_7F00, "R7 edge implemented bits");
    src_n[22] = 1'b0;
    @(negedge clk);
    rd(PLO, onehot(11), "R7 falling edge sets");
    wr(PLO, '1);
    rd(PLO, 32'h0, "R7 held low no retrigger");
    chk(irq_req, 1'b0, "R7 irq after edge clear");
    src_n[22] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(PLO, 32'h0, "R7 rising edge no set");
    pulse(22);
    rd(VEC, 32'd22 << 26, "R7 second edge vec");
    wr(PLO, '1);
    pulse(55);
    rd(PLO, onehot(23), "R7 port edge src55");
    wr(PLO, '1);
    src_n[40] = 1'b0;
    @(negedge clk);
    wr(PHI, '1);
    rd(PHI, onehot(23), "R7 internal ignores edge bit");
    src_n[40] = 1'b1;
    @(negedge clk);
    wr(PHI, '1);
    wr(EDG, '0);

    // R8 lowest number wins
    src_n[50] = 1'b0; src_n[20] = 1'b0; src_n[7] = 1'b0;
    @(negedge clk);
    src_n[50] = 1'b1; src_n[20] = 1'b1; src_n[7] = 1'b1;
    rd(VEC, 32'd7 << 26, "R8 vec lowest 7");
    wr(VEC, '1);
    rd(VEC, 32'd7 << 26, "R9 vec write ignored");
    wr(PHI, onehot(9));
    rd(VEC, 32'd20 << 26, "R8 vec next 20");
    wr(PLO, onehot(13));
    rd(VEC, 32'd50 << 26, "R8 vec next 50");
    wr(PLO, onehot(18));
    rd(VEC, 32'h0, "R8 vec none");
    chk(irq_req, 1'b0, "R4 irq none pending");

    // R9 storage registers
    wr(PRA, 32'hDEAD_BEEF); wr(PRB, 32'h1234_5678); wr(CFG, 32'hFFFF_A5C3);
    rd(PRA, 32'hDEAD_BEEF, "R9 prio_a");
    rd(PRB, 32'h1234_5678, "R9 prio_b");
    rd(CFG, 32'h0000_A5C3, "R9 cfg 16 bits");

    repeat (3) @(negedge clk);
    if (q_exp.size() != 0) begin
      checks++; failures++;
      $display("FAIL R9: got %0d missing responses expected 0", q_exp.size());
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule